// File: doc/BRIEF.md
# Command completion and extended status builder

This block closes out every command of a two-drive diskette controller. While a command runs, the block holds the controller busy. When the media engine reports the end of the command, the block does the following:
- It returns the controller to idle.
- It raises the done flag, and it raises an interrupt request if interrupts are enabled.
- It merges the reported error flags into a sticky error-status word and rebuilds the drive-dependent bits of that word from the currently selected drive.
- It latches the 8-bit error code.
- It copies the status word into the data buffer register, so software can read the outcome without issuing another command.

The block can also assemble an eight-byte extended status record. It presents the record to a DMA stub one byte per cycle, and then completes the command itself. The completion is flagged as a memory fault if the stub reported one while the record was being sent.

The state machine has three states:
- `S_IDLE` leaves to `S_ACTIVE` on an accepted command start.
- `S_ACTIVE` leaves to `S_IDLE` on a finish request (the completion transition). It leaves to `S_XSTAT` on an extended-status request.
- `S_XSTAT` steps through the record and leaves to `S_IDLE` after the last byte (the completion transition).

Top module: `cmd_finish_status`

## Requirements
- R1: After reset the block is idle (`busy`=0), and `done`, `irq`, `csr_err`, `esr`, `ecode`, `dbr` and `xs_valid` are all zero.
- R2: `cmd_start` while idle makes `busy` 1 on the next cycle and clears `done`, `irq` and `csr_err`. `cmd_start` while busy is ignored: none of the outputs it could affect change.
- R3: A start with `cmd_rw`=1 clears every `esr` bit except bit 2 (init done), and it clears `ecode` to zero. A start with `cmd_rw`=0 leaves `esr` and `ecode` unchanged.
- R4: `fin_req` while busy (not streaming) completes the command. On the next cycle `busy`=0 and `done`=1, and in that same cycle `irq` equals `ie`.
- R5: At completion, `esr` becomes the old `esr` OR the new flags masked to bits {0,2,3,4,6,10,11}. Bits 5, 7 and 8 are then rebuilt as follows:
  - bit 8 is set when `drv_sel`=1;
  - bit 7 is set when `drv_att[drv_sel]` is 1;
  - bit 5 is set when both `drv_att[drv_sel]` and `drv_dd[drv_sel]` are 1.
  Bits 1 and 9 always read 0.
- R6: At completion, `csr_err` is set when the new error code is nonzero or any of `esr` bits 0, 3, 4, 10 or 11 is set.
- R7: At completion, `ecode` takes the new code, and `dbr` takes the new `esr` zero-extended to 16 bits.
- R8: `xs_req` while busy starts the record on the next cycle. The record is eight bytes on consecutive cycles, with `xs_valid`=1 and `xs_idx` counting 0 to 7. The bytes, by index, are:
  - 0: `ecode`;
  - 1: `xs_wc`;
  - 2: `trk0`;
  - 3: `trk1`;
  - 4: `req_trk`;
  - 5: `req_sec`;
  - 6: a flags byte, laid out as {`drv_sel`, `drv_dd[1]`, `drv_att[drv_sel]`, `drv_dd[0]`, 3'b000, `den_sel`};
  - 7: the track of the selected drive.
  When both `fin_req` and `xs_req` are high, `fin_req` wins.
- R9: The cycle after byte 7, the record completes as in R4–R7, with error code 0. The new flags are `esr` bit 11 if `dma_fault` was high in any cycle of the record, and none otherwise.
- R10: While `ie` is 0, `irq` is 0 from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a command |
| cmd_rw | input | 1 | Started command is a read or write |
| fin_req | input | 1 | Media engine reports command end |
| fin_flags | input | 12 | Error-status flags to merge |
| fin_code | input | 8 | Error code of the finished command |
| xs_req | input | 1 | Request extended status record |
| dma_fault | input | 1 | DMA stub reports nonexistent memory |
| ie | input | 1 | Interrupt enable |
| drv_sel | input | 1 | Selected drive |
| den_sel | input | 1 | Requested density |
| drv_att | input | 2 | Per-drive attached |
| drv_dd | input | 2 | Per-drive double density |
| xs_wc | input | 8 | Word count |
| trk0 | input | 8 | Drive 0 current track |
| trk1 | input | 8 | Drive 1 current track |
| req_trk | input | 8 | Requested track |
| req_sec | input | 8 | Requested sector |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command done |
| irq | output | 1 | Interrupt request |
| csr_err | output | 1 | Error summary flag |
| esr | output | 12 | Error-status word |
| ecode | output | 8 | Error code |
| dbr | output | 16 | Data buffer register |
| xs_valid | output | 1 | Record byte valid |
| xs_idx | output | 3 | Record byte index |
| xs_byte | output | 8 | Record byte |

## Verification
The hardest case to bring about is the sticky part of `esr` when the drive context changes between completions. An error bit raised by one command must survive a later non-read/write command on the other drive. The drive-dependent bits, however, must be rebuilt from that other drive. The stimulus reaches this case by chaining random start/finish pairs with random `cmd_rw`, drive selection, attach and density patterns, so accumulated flags meet changing drive context. A directed extended-status run asserts `dma_fault` only on the last byte, to reach the case where the fault and the completion fall in the same record window.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_XSTAT} cfs_state_e;

    localparam int ESR_W    = 12;
    localparam int DBR_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int XS_LEN   = 8;
    localparam int XS_IDX_W = $clog2(XS_LEN);

    localparam int B_INIT = 2;
    localparam int B_DDEN = 5;
    localparam int B_RDY  = 7;
    localparam int B_USEL = 8;
    localparam int B_NXM  = 11;

    // implemented, error-summary and drive-rebuilt bit groups
    localparam logic [ESR_W-1:0] ESR_IMPL = 12'hDFD;
    localparam logic [ESR_W-1:0] ESR_ERRS = 12'hC19;
    localparam logic [ESR_W-1:0] ESR_DRV  = 12'h1A0;
endpackage

// File: rtl/cfs_esr_merge.sv
module cfs_esr_merge
    import cfs_pkg::*;
(
    input  logic [ESR_W-1:0] esr_q,
    input  logic [ESR_W-1:0] flags,
    input  logic             drv_sel,
    input  logic [1:0]       drv_att,
    input  logic [1:0]       drv_dd,
    output logic [ESR_W-1:0] esr_d,
    output logic             err_hit
);
    logic att_sel;
    logic dd_sel;

    always_comb begin
        att_sel = drv_att[drv_sel];
        dd_sel  = drv_dd[drv_sel];
        esr_d   = (esr_q | (flags & ESR_IMPL)) & ~ESR_DRV;
        esr_d[B_USEL] = drv_sel;
        esr_d[B_RDY]  = att_sel;
        esr_d[B_DDEN] = att_sel & dd_sel;
        err_hit = |(esr_d & ESR_ERRS);
    end
endmodule

// File: rtl/cfs_xstat_mux.sv
module cfs_xstat_mux
    import cfs_pkg::*;
(
    input  logic [XS_IDX_W-1:0] idx,
    input  logic [BYTE_W-1:0]   code,
    input  logic [BYTE_W-1:0]   wc,
    input  logic [BYTE_W-1:0]   trk0,
    input  logic [BYTE_W-1:0]   trk1,
    input  logic [BYTE_W-1:0]   rtrk,
    input  logic [BYTE_W-1:0]   rsec,
    input  logic                drv_sel,
    input  logic                den_sel,
    input  logic [1:0]          drv_att,
    input  logic [1:0]          drv_dd,
    output logic [BYTE_W-1:0]   byte_o
);
    logic [BYTE_W-1:0] flag_byte;

    always_comb begin
        flag_byte = {drv_sel, drv_dd[1], drv_att[drv_sel], drv_dd[0], 3'b000, den_sel};
        unique case (idx)
            3'd0: byte_o = code;
            3'd1: byte_o = wc;
            3'd2: byte_o = trk0;
            3'd3: byte_o = trk1;
            3'd4: byte_o = rtrk;
            3'd5: byte_o = rsec;
            3'd6: byte_o = flag_byte;
            3'd7: byte_o = drv_sel ? trk1 : trk0;
        endcase
    end
endmodule

// File: rtl/cmd_finish_status.sv
module cmd_finish_status
    import cfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_rw,
    input  logic              fin_req,
    input  logic [11:0]       fin_flags,
    input  logic [7:0]        fin_code,
    input  logic              xs_req,
    input  logic              dma_fault,
    input  logic              ie,
    input  logic              drv_sel,
    input  logic              den_sel,
    input  logic [1:0]        drv_att,
    input  logic [1:0]        drv_dd,
    input  logic [7:0]        xs_wc,
    input  logic [7:0]        trk0,
    input  logic [7:0]        trk1,
    input  logic [7:0]        req_trk,
    input  logic [7:0]        req_sec,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              csr_err,
    output logic [11:0]       esr,
    output logic [7:0]        ecode,
    output logic [15:0]       dbr,
    output logic              xs_valid,
    output logic [2:0]        xs_idx,
    output logic [7:0]        xs_byte
);
    localparam logic [XS_IDX_W-1:0] LAST_IDX = XS_IDX_W'(XS_LEN - 1);

    cfs_state_e           state_q, state_d;
    logic [ESR_W-1:0]     esr_q;
    logic [BYTE_W-1:0]    code_q;
    logic [DBR_W-1:0]     dbr_q;
    logic                 done_q, irq_q, err_q, fault_q;
    logic [XS_IDX_W-1:0]  idx_q;

    logic                 accept_start, fin_now;
    logic [ESR_W-1:0]     flags_eff, esr_merged;
    logic [BYTE_W-1:0]    code_eff;
    logic                 err_hit;

    always_comb begin
        accept_start = (state_q == S_IDLE) && cmd_start;
        fin_now      = ((state_q == S_ACTIVE) && fin_req) ||
                       ((state_q == S_XSTAT) && (idx_q == LAST_IDX));
        flags_eff    = '0;
        code_eff     = fin_code;
        if (state_q == S_XSTAT) begin
            flags_eff[B_NXM] = fault_q | dma_fault;
            code_eff         = '0;
        end else begin
            flags_eff = fin_flags;
        end
    end

    cfs_esr_merge u_merge (
        .esr_q   (esr_q),
        .flags   (flags_eff),
        .drv_sel (drv_sel),
        .drv_att (drv_att),
        .drv_dd  (drv_dd),
        .esr_d   (esr_merged),
        .err_hit (err_hit)
    );

    cfs_xstat_mux u_xmux (
        .idx     (idx_q),
        .code    (code_q),
        .wc      (xs_wc),
        .trk0    (trk0),
        .trk1    (trk1),
        .rtrk    (req_trk),
        .rsec    (req_sec),
        .drv_sel (drv_sel),
        .den_sel (den_sel),
        .drv_att (drv_att),
        .drv_dd  (drv_dd),
        .byte_o  (xs_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (cmd_start) state_d = S_ACTIVE;
            S_ACTIVE: if (fin_req) state_d = S_IDLE;
                      else if (xs_req) state_d = S_XSTAT;
            S_XSTAT:  if (idx_q == LAST_IDX) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q   <= '0;
            code_q  <= '0;
            dbr_q   <= '0;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
            err_q   <= 1'b0;
            fault_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (accept_start) begin
                done_q <= 1'b0;
                irq_q  <= 1'b0;
                err_q  <= 1'b0;
                if (cmd_rw) begin
                    esr_q  <= esr_q & (ESR_W'(1) << B_INIT);
                    code_q <= '0;
                end
            end else if (fin_now) begin
                done_q <= 1'b1;
                irq_q  <= ie;
                err_q  <= (code_eff != '0) || err_hit;
                esr_q  <= esr_merged;
                code_q <= code_eff;
                dbr_q  <= DBR_W'(esr_merged);
            end else if (!ie) begin
                irq_q <= 1'b0;
            end

            if (state_q == S_XSTAT) begin
                idx_q   <= idx_q + 1'b1;
                fault_q <= fault_q | dma_fault;
            end else begin
                idx_q   <= '0;
                fault_q <= 1'b0;
            end
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign irq      = irq_q;
    assign csr_err  = err_q;
    assign esr      = esr_q;
    assign ecode    = code_q;
    assign dbr      = dbr_q;
    assign xs_valid = (state_q == S_XSTAT);
    assign xs_idx   = idx_q;
endmodule

// File: rtl/cmd_finish_status_chk.sv
module cmd_finish_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start,
    input logic        ie,
    input logic        busy,
    input logic        done,
    input logic        irq,
    input logic        csr_err,
    input logic [11:0] esr,
    input logic [15:0] dbr,
    input logic        xs_valid,
    input logic [2:0]  xs_idx
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> (busy && !done && !irq && !csr_err)); // R2

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy); // R4

    AST_DBR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (dbr == {4'b0000, esr})); // R7

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((esr & 12'hC19) != 12'h000)) |-> csr_err); // R6

    AST_XS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (xs_valid && $past(xs_valid)) |-> (xs_idx == $past(xs_idx) + 3'd1)); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !irq); // R10
endmodule

bind cmd_finish_status cmd_finish_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .ie        (ie),
    .busy      (busy),
    .done      (done),
    .irq       (irq),
    .csr_err   (csr_err),
    .esr       (esr),
    .dbr       (dbr),
    .xs_valid  (xs_valid),
    .xs_idx    (xs_idx)
);

// File: tb/cmd_finish_status_bench.sv
module cmd_finish_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_rw = 0, fin_req = 0, xs_req = 0, dma_fault = 0;
    logic ie = 0, drv_sel = 0, den_sel = 0;
    logic [11:0] fin_flags = '0;
    logic [7:0]  fin_code = '0, xs_wc = '0, trk0 = '0, trk1 = '0, req_trk = '0, req_sec = '0;
    logic [1:0]  drv_att = '0, drv_dd = '0;
    logic busy, done, irq, csr_err, xs_valid;
    logic [11:0] esr;
    logic [7:0]  ecode, xs_byte;
    logic [15:0] dbr;
    logic [2:0]  xs_idx;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_esr = '0;
    logic [7:0]  m_code = '0;

    always #2 clk = ~clk;

    cmd_finish_status u_cmd_finish_status (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rw(cmd_rw),
        .fin_req(fin_req), .fin_flags(fin_flags), .fin_code(fin_code),
        .xs_req(xs_req), .dma_fault(dma_fault), .ie(ie), .drv_sel(drv_sel),
        .den_sel(den_sel), .drv_att(drv_att), .drv_dd(drv_dd), .xs_wc(xs_wc),
        .trk0(trk0), .trk1(trk1), .req_trk(req_trk), .req_sec(req_sec),
        .busy(busy), .done(done), .irq(irq), .csr_err(csr_err), .esr(esr),
        .ecode(ecode), .dbr(dbr), .xs_valid(xs_valid), .xs_idx(xs_idx),
        .xs_byte(xs_byte)
    );

    function automatic logic [11:0] exp_esr(input logic [11:0] old, input logic [11:0] f);
        logic [11:0] e;
        e = (old | (f & 12'hDFD)) & ~12'h1A0;
        if (drv_sel) e[8] = 1'b1;
        if (drv_att[drv_sel]) e[7] = 1'b1;
        if (drv_att[drv_sel] && drv_dd[drv_sel]) e[5] = 1'b1;
        return e;
    endfunction

    function automatic logic [7:0] exp_xbyte(input int k);
        case (k)
            0: return m_code;
            1: return xs_wc;
            2: return trk0;
            3: return trk1;
            4: return req_trk;
            5: return req_sec;
            6: return {drv_sel, drv_dd[1], drv_att[drv_sel], drv_dd[0], 3'b000, den_sel};
            default: return drv_sel ? trk1 : trk0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_start(input logic rw);
        @(negedge clk);
        cmd_start = 1; cmd_rw = rw;
        @(posedge clk); #1;
        cmd_start = 0;
        if (rw) begin m_esr = m_esr & 12'h004; m_code = 0; end
        chk("R2 busy", busy, 1); chk("R2 done", done, 0); chk("R2 irq", irq, 0);
        chk("R2 err", csr_err, 0);
        chk("R3 esr", esr, m_esr); chk("R3 ecode", ecode, m_code);
    endtask

    task automatic do_fin(input logic [11:0] f, input logic [7:0] c);
        logic e;
        @(negedge clk);
        fin_req = 1; fin_flags = f; fin_code = c;
        @(posedge clk); #1;
        fin_req = 0;
        m_esr = exp_esr(m_esr, f); m_code = c;
        e = (c != 0) || ((m_esr & 12'hC19) != 0);
        chk("R4 busy", busy, 0); chk("R4 done", done, 1); chk("R4 irq", irq, ie);
        chk("R5 esr", esr, m_esr); chk("R6 err", csr_err, e);
        chk("R7 ecode", ecode, m_code); chk("R7 dbr", dbr, {4'b0, m_esr});
    endtask

    task automatic do_xstat(input logic [7:0] fault_mask);
        logic seen = 0;
        @(negedge clk);
        xs_req = 1;
        @(posedge clk); #1;
        xs_req = 0;
        for (int k = 0; k < 8; k++) begin
            chk("R8 valid", xs_valid, 1); chk("R8 idx", xs_idx, k);
            chk("R8 byte", xs_byte, exp_xbyte(k));
            dma_fault = fault_mask[k];
            if (fault_mask[k]) seen = 1;
            @(posedge clk); #1;
        end
        dma_fault = 0;
        m_esr = exp_esr(m_esr, seen ? 12'h800 : 12'h000); m_code = 0;
        chk("R9 valid", xs_valid, 0); chk("R9 done", done, 1); chk("R9 busy", busy, 0);
        chk("R9 esr", esr, m_esr); chk("R9 ecode", ecode, 0);
        chk("R9 err", csr_err, (m_esr & 12'hC19) != 0);
    endtask

    task automatic rand_ctx();
        drv_sel = 1'($urandom); den_sel = 1'($urandom);
        drv_att = 2'($urandom); drv_dd = 2'($urandom); ie = 1'($urandom);
        xs_wc = 8'($urandom); trk0 = 8'($urandom); trk1 = 8'($urandom);
        req_trk = 8'($urandom); req_sec = 8'($urandom);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 irq", irq, 0);
        chk("R1 err", csr_err, 0); chk("R1 esr", esr, 0); chk("R1 ecode", ecode, 0);
        chk("R1 dbr", dbr, 0); chk("R1 xs_valid", xs_valid, 0);

        // directed: fin with error flags on drive 1, attached, double density
        ie = 1; drv_sel = 1; drv_att = 2'b10; drv_dd = 2'b10;
        do_start(1);
        do_fin(12'hFFF, 8'h00);
        // R2: start while busy ignored
        do_start(0);
        @(negedge clk); cmd_start = 1; cmd_rw = 1;
        @(posedge clk); #1; cmd_start = 0;
        chk("R2 ignored esr", esr, m_esr); chk("R2 ignored busy", busy, 1);
        do_fin(12'h000, 8'h40);
        // R10: ie drop clears irq
        @(negedge clk); ie = 0;
        @(posedge clk); #1;
        chk("R10 irq", irq, 0); chk("R10 done", done, 1);
        // R3: read/write start clears errors except init done
        do_start(0);
        do_fin(12'h004, 8'h00);
        do_start(1);
        // R9: fault only on last byte
        drv_sel = 0; drv_att = 2'b01; drv_dd = 2'b01; trk0 = 8'h11; trk1 = 8'h22;
        do_xstat(8'h80);
        do_start(1);
        do_xstat(8'h00);

        for (int i = 0; i < 150; i++) begin
            rand_ctx();
            do_start(1'($urandom));
            if (($urandom % 4) == 0) do_xstat(8'($urandom) & 8'h21);
            else do_fin(12'($urandom) & (($urandom % 2) ? 12'hFFF : 12'h044),
                        (($urandom % 3) == 0) ? 8'($urandom) : 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule